// File: doc/BRIEF.md
# Pending-Read Associative Store

This block holds the return routing of reads that arrived at memory cells which were not yet written. Each pending read takes one slot that keeps the cell address and a 16-bit routing word. The cell controller uses three request ports. An allocate port stores a new pending read. A write-lookup port presents the address of every write. A cancel port presents the address of every clear or free. The allocate port picks the lowest-numbered free slot. It refuses the request when no slot is free, and it also refuses an address that is already pending.

The write-lookup port compares its address with every valid slot in the same cycle. On a hit it returns that slot's routing word combinationally and frees the slot at the next clock edge. The controller can then form the result token for the read it had deferred. A cancel frees the matching slot and produces no output. The `full` flag reports that every slot is occupied, so that the controller stalls further deferred reads.

Lookups and cancels are applied before allocation within a cycle. A slot released in a cycle can therefore be given to an allocation presented in that same cycle.

Top module: `pending_read_store`

## Requirements
- R1: After reset every slot is invalid: `full` is 0, and a lookup of any address gives `look_hit`=0 and `look_route`=0.
- R2: An accepted allocation (`alloc_ok`=1 in the same cycle as `alloc_req`) goes into the lowest-numbered free slot. `alloc_slot` gives that slot's binary index in the same cycle, and the entry is valid from the next clock edge.
- R3: `full` is 1 exactly when all NUM_SLOTS slots are valid. With `full`=1, and no lookup hit or cancel hit in that cycle, an allocation is refused (`alloc_ok`=0) and no stored entry changes.
- R4: A lookup whose address equals a valid slot's address gives `look_hit`=1 and that slot's routing on `look_route` in the same cycle. The slot is invalid from the next edge, so a repeated lookup of the same address misses.
- R5: A lookup that matches no valid slot gives `look_hit`=0 and `look_route`=0, and it changes no entry.
- R6: A cancel frees the valid slot whose address equals `cancel_addr`, has no output, and leaves every other slot unchanged.
- R7: An allocation whose address equals a slot that stays valid through the cycle raises `dup_err` in that cycle and is refused (`alloc_ok`=0). The stored entry keeps its original routing.
- R8: A lookup hit or cancel hit is applied before an allocation in the same cycle. When the store is full, the slot freed in that cycle is granted to the allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request to store a pending read |
| alloc_addr | input | ADDR_W | Cell address of the pending read |
| alloc_route | input | ROUTE_W | Return routing word to keep |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_slot | output | IDX_W | Index of the granted slot |
| dup_err | output | 1 | Allocation address already pending |
| full | output | 1 | Every slot is occupied |
| look_req | input | 1 | Write address lookup request |
| look_addr | input | ADDR_W | Address of the write |
| look_hit | output | 1 | A pending read matches the write |
| look_route | output | ROUTE_W | Routing of the matching slot, 0 on a miss |
| cancel_req | input | 1 | Clear or free request |
| cancel_addr | input | ADDR_W | Address being cleared or freed |

## Verification
The bench fills the store in order and checks that each grant goes to the lowest free index. A wrong priority encoder would hand out a higher slot, or reuse a busy one and lose a routing word. It checks that a full store refuses allocation and keeps its contents, and that a looked-up slot misses on a second lookup. A design that failed to free the slot would return stale routing twice. It checks that a freed hole is the next slot reused. It also checks the same-cycle cases, a lookup or cancel together with an allocation into a full store, and a duplicate address. A design that ordered the allocation first would refuse the allocation or overwrite a live slot. A design without the duplicate check would create two slots that both answer one write.

// File: rtl/prs_pkg.sv
package prs_pkg;

  localparam int MAXW = 64;

  function automatic logic [MAXW-1:0] lowest_set(input logic [MAXW-1:0] mask);
    return mask & (~mask + 64'd1);
  endfunction

  function automatic int onehot_index(input logic [MAXW-1:0] oh);
    int idx;
    idx = 0;
    for (int i = 0; i < MAXW; i++) begin
      if (oh[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/prs_slot.sv
module prs_slot #(
  parameter int ADDR_W  = 10,
  parameter int ROUTE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               drop,
  input  logic [ADDR_W-1:0]  addr_in,
  input  logic [ROUTE_W-1:0] route_in,
  output logic               valid,
  output logic [ADDR_W-1:0]  addr,
  output logic [ROUTE_W-1:0] route
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      route <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        addr  <= addr_in;
        route <= route_in;
      end else if (drop) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prs_match.sv
module prs_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 10
) (
  input  logic                      en,
  input  logic [ADDR_W-1:0]         key,
  input  logic [N-1:0]              valid,
  input  logic [N-1:0][ADDR_W-1:0]  addrs,
  output logic [N-1:0]              hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = en && valid[g] && (addrs[g] == key);
  end

endmodule

// File: rtl/prs_pick.sv
module prs_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     free_mask,
  output logic [N-1:0]     grant,
  output logic             any_free,
  output logic [IDX_W-1:0] index
);
  import prs_pkg::*;

  localparam int PAD = MAXW - N;

  logic [MAXW-1:0] wide_oh;

  assign wide_oh  = lowest_set({{PAD{1'b0}}, free_mask});
  assign grant    = wide_oh[N-1:0];
  assign any_free = |free_mask;
  assign index    = IDX_W'(onehot_index(wide_oh));

endmodule

// File: rtl/pending_read_store.sv
module pending_read_store #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 10,
  parameter int ROUTE_W   = 16,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_req,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  logic [ROUTE_W-1:0] alloc_route,
  output logic               alloc_ok,
  output logic [IDX_W-1:0]   alloc_slot,
  output logic               dup_err,
  output logic               full,
  input  logic               look_req,
  input  logic [ADDR_W-1:0]  look_addr,
  output logic               look_hit,
  output logic [ROUTE_W-1:0] look_route,
  input  logic               cancel_req,
  input  logic [ADDR_W-1:0]  cancel_addr
);

  logic [NUM_SLOTS-1:0]              valid_q;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  addr_q;
  logic [NUM_SLOTS-1:0][ROUTE_W-1:0] route_q;

  // Named internal events, used by the checker
  logic [NUM_SLOTS-1:0] look_vec;
  logic [NUM_SLOTS-1:0] cancel_vec;
  logic [NUM_SLOTS-1:0] release_vec;
  logic [NUM_SLOTS-1:0] kept_vec;
  logic [NUM_SLOTS-1:0] dup_vec;
  logic [NUM_SLOTS-1:0] free_mask;
  logic [NUM_SLOTS-1:0] grant;
  logic [NUM_SLOTS-1:0] load_vec;
  logic                 any_free;

  prs_match #(.N(NUM_SLOTS), .ADDR_W(ADDR_W)) u_look_cmp (
    .en(look_req), .key(look_addr), .valid(valid_q), .addrs(addr_q), .hit(look_vec)
  );

  prs_match #(.N(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cancel_cmp (
    .en(cancel_req), .key(cancel_addr), .valid(valid_q), .addrs(addr_q), .hit(cancel_vec)
  );

  // Releases this cycle come first; what is left decides duplicates and grants
  assign release_vec = look_vec | cancel_vec;
  assign kept_vec    = valid_q & ~release_vec;
  assign free_mask   = ~kept_vec;

  prs_match #(.N(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dup_cmp (
    .en(alloc_req), .key(alloc_addr), .valid(kept_vec), .addrs(addr_q), .hit(dup_vec)
  );

  prs_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .free_mask(free_mask), .grant(grant), .any_free(any_free), .index(alloc_slot)
  );

  assign dup_err  = |dup_vec;
  assign alloc_ok = alloc_req && any_free && !dup_err;
  assign load_vec = alloc_ok ? grant : '0;
  assign full     = &valid_q;
  assign look_hit = |look_vec;

  always_comb begin
    look_route = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (look_vec[i]) look_route = look_route | route_q[i];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    prs_slot #(.ADDR_W(ADDR_W), .ROUTE_W(ROUTE_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(load_vec[g]), .drop(release_vec[g]),
      .addr_in(alloc_addr), .route_in(alloc_route),
      .valid(valid_q[g]), .addr(addr_q[g]), .route(route_q[g])
    );
  end

endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         alloc_req,
  input logic         alloc_ok,
  input logic         dup_err,
  input logic         full,
  input logic         look_hit,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] look_vec,
  input logic [N-1:0] cancel_vec,
  input logic [N-1:0] free_mask,
  input logic [N-1:0] grant
);

  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_grant_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (((grant & free_mask) == grant) && (((grant - 1'b1) & free_mask) == '0)));

  a_r2_grant_lands: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> ((valid_q & $past(grant)) == $past(grant)));

  a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_req && (look_vec == '0) && (cancel_vec == '0)) |-> !alloc_ok);

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && (look_vec == '0) && (cancel_vec == '0)) |=> full);

  a_r4_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && !alloc_ok && (cancel_vec == '0)) |=>
      ($countones(valid_q) == $countones($past(valid_q)) - 1));

  a_r6_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_vec) && $onehot0(cancel_vec));

  a_r7_dup_refused: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> !alloc_ok);

endmodule

bind pending_read_store prs_checker #(.N(NUM_SLOTS)) u_prs_checker (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
  .dup_err(dup_err), .full(full), .look_hit(look_hit), .valid_q(valid_q),
  .look_vec(look_vec), .cancel_vec(cancel_vec), .free_mask(free_mask), .grant(grant)
);

// File: tb/pending_read_store_bench.sv
module pending_read_store_bench;

  localparam int N  = 4;
  localparam int AW = 10;
  localparam int RW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_req = 1'b0;
  logic [AW-1:0] alloc_addr = '0;
  logic [RW-1:0] alloc_route = '0;
  logic          alloc_ok;
  logic [IW-1:0] alloc_slot;
  logic          dup_err;
  logic          full;
  logic          look_req = 1'b0;
  logic [AW-1:0] look_addr = '0;
  logic          look_hit;
  logic [RW-1:0] look_route;
  logic          cancel_req = 1'b0;
  logic [AW-1:0] cancel_addr = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pending_read_store #(.NUM_SLOTS(N), .ADDR_W(AW), .ROUTE_W(RW)) u_pending_read_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_addr(alloc_addr), .alloc_route(alloc_route),
    .alloc_ok(alloc_ok), .alloc_slot(alloc_slot), .dup_err(dup_err), .full(full),
    .look_req(look_req), .look_addr(look_addr), .look_hit(look_hit), .look_route(look_route),
    .cancel_req(cancel_req), .cancel_addr(cancel_addr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs are set just after a falling edge; outputs are sampled 1 ns later
  task automatic settle();
    #1;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    @(negedge clk);
    alloc_req = 1'b0; look_req = 1'b0; cancel_req = 1'b0;
  endtask

  task automatic do_alloc(input string req, input int a, input int r,
                          input int exp_ok, input int exp_slot);
    alloc_req = 1'b1; alloc_addr = AW'(a); alloc_route = RW'(r);
    settle();
    check(req, "alloc_ok", int'(alloc_ok), exp_ok);
    if (exp_ok != 0) check(req, "alloc_slot", int'(alloc_slot), exp_slot);
    finish_cycle();
  endtask

  task automatic do_look(input string req, input int a, input int exp_hit, input int exp_route);
    look_req = 1'b1; look_addr = AW'(a);
    settle();
    check(req, "look_hit", int'(look_hit), exp_hit);
    check(req, "look_route", int'(look_route), exp_route);
    finish_cycle();
  endtask

  task automatic do_cancel(input int a);
    cancel_req = 1'b1; cancel_addr = AW'(a);
    finish_cycle();
  endtask

  task automatic t_reset();
    settle();
    check("R1", "full", int'(full), 0);
    do_look("R1", 0, 0, 0);
  endtask

  task automatic t_fill();
    do_alloc("R2", 5, 16'h1111, 1, 0);
    do_alloc("R2", 6, 16'h2222, 1, 1);
    do_alloc("R2", 7, 16'h3333, 1, 2);
    check("R3", "full at three", int'(full), 0);
    do_alloc("R2", 8, 16'h4444, 1, 3);
    settle();
    check("R3", "full at four", int'(full), 1);
  endtask

  task automatic t_full_refuse();
    do_alloc("R3", 9, 16'h9999, 0, 0);
    do_look("R3", 9, 0, 0);
    do_look("R3", 8, 1, 16'h4444);
    do_alloc("R2", 8, 16'h4444, 1, 3);
  endtask

  task automatic t_lookup();
    do_look("R4", 6, 1, 16'h2222);
    do_look("R4", 6, 0, 0);
    settle();
    check("R4", "full after hit", int'(full), 0);
    do_look("R5", 12, 0, 0);
    do_alloc("R2", 20, 16'h2020, 1, 1);
  endtask

  task automatic t_cancel();
    do_cancel(7);
    do_look("R6", 7, 0, 0);
    do_alloc("R6", 30, 16'h3030, 1, 2);
    do_alloc("R6", 31, 16'h3131, 0, 0);
  endtask

  task automatic t_dup();
    do_cancel(5);
    alloc_req = 1'b1; alloc_addr = AW'(30); alloc_route = RW'(16'hDEAD);
    settle();
    check("R7", "dup_err", int'(dup_err), 1);
    check("R7", "alloc_ok", int'(alloc_ok), 0);
    finish_cycle();
    do_look("R7", 30, 1, 16'h3030);
  endtask

  task automatic t_same_cycle();
    // slots now: 1:20, 3:8 valid; 0 and 2 free
    do_alloc("R8", 40, 16'h4040, 1, 0);
    do_alloc("R8", 41, 16'h4141, 1, 2);
    settle();
    check("R8", "full before", int'(full), 1);
    look_req = 1'b1; look_addr = AW'(20);
    alloc_req = 1'b1; alloc_addr = AW'(50); alloc_route = RW'(16'h5050);
    settle();
    check("R8", "look_hit", int'(look_hit), 1);
    check("R8", "alloc_ok with lookup", int'(alloc_ok), 1);
    check("R8", "alloc_slot with lookup", int'(alloc_slot), 1);
    finish_cycle();
    cancel_req = 1'b1; cancel_addr = AW'(8);
    alloc_req = 1'b1; alloc_addr = AW'(60); alloc_route = RW'(16'h6060);
    settle();
    check("R8", "alloc_ok with cancel", int'(alloc_ok), 1);
    check("R8", "alloc_slot with cancel", int'(alloc_slot), 3);
    finish_cycle();
    do_look("R8", 50, 1, 16'h5050);
    do_look("R8", 60, 1, 16'h6060);
    do_look("R8", 8, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_full_refuse();
        t_lookup();
        t_cancel();
        t_dup();
        t_same_cycle();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual expired expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule